// File: doc/BRIEF.md
# Multidrop Serial Character Receiver

This block turns an asynchronous serial line into 8-bit or 9-bit characters. A pulse on `os_tick` comes sixteen times per bit period. On each frame the block checks the start bit at the bit centre, shifts in the data bits, and then tests the stop bit. Every character it keeps goes into a small holding queue, together with its ninth bit and its framing-error flag. Software reads the queue one entry at a time.

On a shared bus, a node can turn on address filtering in 9-bit mode. The node then drops every character whose ninth bit is clear, and only characters flagged as addresses reach the queue. If the queue is full when a kept character completes, the block raises a sticky overrun flag and refuses further characters until the receiver is switched off and on again.

Top module: `mdrop_rx`

## Requirements
- R1: After reset, `rx_irq` and `ovr_err` are low.
- R2: In 8-bit mode (`nine_bit`=0), a frame is one low start bit, eight data bits sent least significant bit first, and one stop bit. The frame is presented on `rd_data` with `rd_bit9`=0.
- R3: In 9-bit mode (`nine_bit`=1), a ninth bit follows the eight data bits. It is presented on `rd_bit9` with that character.
- R4: If the stop bit is sampled low, `rd_ferr` is 1 for that character. If it is sampled high, `rd_ferr` is 0.
- R5: Each bit is decided by a majority of three samples taken at ticks 7, 8 and 9 of its 16-tick period. A low pulse that has ended before the start bit's centre receives nothing, and the receiver returns to idle.
- R6: The queue holds up to two characters and returns them oldest first. `rx_irq` is high exactly while the queue is not empty. A pulse on `rd_stb` removes the head entry.
- R7: If a kept character completes while the queue is full, `ovr_err` rises. The character is discarded and the stored entries are left intact.
- R8: While `ovr_err` is high, no character enters the queue, even after the queue has been read empty. Holding `rx_en` low for one cycle clears `ovr_err`.
- R9: With `addr_filt`=1 in 9-bit mode, a character whose ninth bit is 0 is discarded and never sets `ovr_err`. A character whose ninth bit is 1 is kept. `addr_filt` has no effect in 8-bit mode.
- R10: `rd_stb` on an empty queue has no effect.
- R11: While `rx_en` is low, activity on the line produces no character.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| rx_line | input | 1 | Serial input line, idle high |
| os_tick | input | 1 | One-cycle pulse at 16x the bit rate |
| rx_en | input | 1 | Receiver enable; low also clears overrun |
| nine_bit | input | 1 | 1 selects 9-bit characters |
| addr_filt | input | 1 | 1 keeps only characters with the ninth bit set (9-bit mode) |
| rd_stb | input | 1 | Removes the head queue entry |
| rd_data | output | 8 | Data of head entry |
| rd_bit9 | output | 1 | Ninth bit of head entry |
| rd_ferr | output | 1 | Framing error of head entry |
| ovr_err | output | 1 | Sticky overrun flag |
| rx_irq | output | 1 | Queue not empty |

## Verification
Single characters are driven with these byte patterns:
- alternating bits, to show bit order;
- a lone LSB or a lone MSB set, to expose shifts off by one position;
- stop bits both high and low, to separate framing-error cases.

Ninth-bit values 0 and 1 are crossed with the filter on and off. This shows that the filter drops only data characters in 9-bit mode and is inert in 8-bit mode. Directed sequences then cover the following:
- a short low glitch, separating a majority-voted start from an edge-triggered one;
- three unread characters, showing which two survive;
- a read-out while overrun is set, proving that the lockout holds until the enable is toggled;
- reads on an empty queue;
- traffic while the receiver is disabled.

// File: rtl/mdrop_rx_pkg.sv
package mdrop_rx_pkg;
  localparam int DATA_W = 8;

  typedef struct packed {
    logic              ferr;
    logic              bit9;
    logic [DATA_W-1:0] data;
  } rx_word_t;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_START = 2'd1,
    ST_DATA  = 2'd2,
    ST_STOP  = 2'd3
  } rx_state_t;

  function automatic logic maj3(input logic a, input logic b, input logic c);
    return (a & b) | (a & c) | (b & c);
  endfunction

  // a completed character passes the address filter
  function automatic logic filt_pass(input logic nine, input logic filt, input logic b9);
    return !(nine && filt) || b9;
  endfunction
endpackage

// File: rtl/mdrop_rx_sync.sv
module mdrop_rx_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic din,
  output logic dout
);
  logic [STAGES-1:0] chain;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain <= '1;
    else        chain <= {chain[STAGES-2:0], din};
  end

  assign dout = chain[STAGES-1];
endmodule

// File: rtl/mdrop_rx_deser.sv
module mdrop_rx_deser
  import mdrop_rx_pkg::*;
#(
  parameter int OSR = 16
) (
  input  logic     clk,
  input  logic     rst_n,
  input  logic     clr,
  input  logic     line,
  input  logic     tick,
  input  logic     nine,
  output logic     done,
  output rx_word_t word
);
  localparam int PH_W  = $clog2(OSR);
  localparam int MID   = OSR / 2;
  localparam int IDX_W = $clog2(DATA_W + 1);

  rx_state_t        st;
  logic [PH_W-1:0]  ph;
  logic [IDX_W-1:0] idx;
  logic [DATA_W:0]  sh;
  logic             s0, s1;
  logic             vote_pt;
  logic             vote;
  logic [IDX_W-1:0] last_idx;

  assign vote_pt  = tick && (st != ST_IDLE) && (ph == PH_W'(MID + 1));
  assign vote     = maj3(s0, s1, line);
  assign last_idx = nine ? IDX_W'(DATA_W) : IDX_W'(DATA_W - 1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st   <= ST_IDLE;
      ph   <= '0;
      idx  <= '0;
      sh   <= '0;
      s0   <= 1'b1;
      s1   <= 1'b1;
      done <= 1'b0;
      word <= '0;
    end else if (clr) begin
      st   <= ST_IDLE;
      ph   <= '0;
      idx  <= '0;
      done <= 1'b0;
    end else begin
      done <= 1'b0;
      if (tick) begin
        if (st == ST_IDLE) begin
          if (!line) begin
            st <= ST_START;
            ph <= PH_W'(1);
          end
        end else begin
          ph <= ph + 1'b1;
          if (ph == PH_W'(MID - 1)) s0 <= line;
          if (ph == PH_W'(MID))     s1 <= line;
        end
      end
      if (vote_pt) begin
        case (st)
          ST_START: begin
            if (vote) st <= ST_IDLE;
            else begin
              st  <= ST_DATA;
              idx <= '0;
              sh  <= '0;
            end
          end
          ST_DATA: begin
            sh[idx] <= vote;
            if (idx == last_idx) st <= ST_STOP;
            else                 idx <= idx + 1'b1;
          end
          ST_STOP: begin
            st        <= ST_IDLE;
            done      <= 1'b1;
            word.data <= sh[DATA_W-1:0];
            word.bit9 <= nine ? sh[DATA_W] : 1'b0;
            word.ferr <= !vote;
          end
          default: st <= ST_IDLE;
        endcase
      end
    end
  end
endmodule

// File: rtl/mdrop_rx_fifo.sv
module mdrop_rx_fifo #(
  parameter int W     = 10,
  parameter int DEPTH = 2
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       wr,
  input  logic [W-1:0]               wdata,
  input  logic                       rd,
  output logic [W-1:0]               rdata,
  output logic                       full,
  output logic                       empty,
  output logic [$clog2(DEPTH+1)-1:0] level
);
  localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int LW = $clog2(DEPTH + 1);

  logic [W-1:0]  mem [DEPTH];
  logic [PW-1:0] wp, rp;
  logic          push, pop;

  assign empty = (level == '0);
  assign full  = (level == LW'(DEPTH));
  assign push  = wr && !full;
  assign pop   = rd && !empty;
  assign rdata = mem[rp];

  function automatic logic [PW-1:0] bump(input logic [PW-1:0] p);
    return (p == PW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wp    <= '0;
      rp    <= '0;
      level <= '0;
      for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
    end else begin
      if (push) begin
        mem[wp] <= wdata;
        wp      <= bump(wp);
      end
      if (pop) rp <= bump(rp);
      case ({push, pop})
        2'b10:   level <= level + 1'b1;
        2'b01:   level <= level - 1'b1;
        default: level <= level;
      endcase
    end
  end
endmodule

// File: rtl/mdrop_rx.sv
module mdrop_rx
  import mdrop_rx_pkg::*;
#(
  parameter int OSR        = 16,
  parameter int FIFO_DEPTH = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rx_line,
  input  logic              os_tick,
  input  logic              rx_en,
  input  logic              nine_bit,
  input  logic              addr_filt,
  input  logic              rd_stb,
  output logic [DATA_W-1:0] rd_data,
  output logic              rd_bit9,
  output logic              rd_ferr,
  output logic              ovr_err,
  output logic              rx_irq
);
  localparam int WORD_W = $bits(rx_word_t);
  localparam int LVL_W  = $clog2(FIFO_DEPTH + 1);

  logic             line_s;
  logic             char_done;
  rx_word_t         char_word;
  logic             char_keep;
  logic             fifo_wr;
  logic             fifo_full;
  logic             fifo_empty;
  logic [LVL_W-1:0] fifo_level;
  rx_word_t         head;

  mdrop_rx_sync #(.STAGES(2)) u_sync (
    .clk(clk), .rst_n(rst_n), .din(rx_line), .dout(line_s)
  );

  mdrop_rx_deser #(.OSR(OSR)) u_deser (
    .clk(clk), .rst_n(rst_n), .clr(!rx_en), .line(line_s), .tick(os_tick),
    .nine(nine_bit), .done(char_done), .word(char_word)
  );

  assign char_keep = char_done && !ovr_err &&
                     filt_pass(nine_bit, addr_filt, char_word.bit9);
  assign fifo_wr   = char_keep && !fifo_full;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                      ovr_err <= 1'b0;
    else if (!rx_en)                 ovr_err <= 1'b0;
    else if (char_keep && fifo_full) ovr_err <= 1'b1;
  end

  mdrop_rx_fifo #(.W(WORD_W), .DEPTH(FIFO_DEPTH)) u_fifo (
    .clk(clk), .rst_n(rst_n), .wr(fifo_wr), .wdata(char_word), .rd(rd_stb),
    .rdata(head), .full(fifo_full), .empty(fifo_empty), .level(fifo_level)
  );

  assign rd_data = head.data;
  assign rd_bit9 = head.bit9;
  assign rd_ferr = head.ferr;
  assign rx_irq  = !fifo_empty;
endmodule

// File: rtl/mdrop_rx_chk.sv
module mdrop_rx_chk #(
  parameter int LVL_W = 2
) (
  input logic             clk,
  input logic             rst_n,
  input logic             rx_en,
  input logic             rd_stb,
  input logic             nine_bit,
  input logic             addr_filt,
  input logic             char_done,
  input logic             char_bit9,
  input logic             char_keep,
  input logic             fifo_full,
  input logic             fifo_wr,
  input logic [LVL_W-1:0] fifo_level,
  input logic             ovr_err,
  input logic             rx_irq
);
  assert_ovr_on_full_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (char_keep && fifo_full) |=> ovr_err);

  assert_ovr_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (ovr_err && rx_en) |=> ovr_err);

  assert_ovr_clear_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !rx_en |=> !ovr_err);

  assert_no_load_in_ovr_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (ovr_err && !rd_stb) |=> $stable(fifo_level));

  assert_filter_drop_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (char_done && nine_bit && addr_filt && !char_bit9 && !rd_stb) |=> $stable(fifo_level));

  assert_irq_on_write_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (fifo_wr && !rd_stb) |=> rx_irq);

  assert_empty_read_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (!rx_irq && !fifo_wr) |=> !rx_irq);
endmodule

bind mdrop_rx mdrop_rx_chk #(.LVL_W($clog2(FIFO_DEPTH + 1))) u_chk (
  .clk(clk), .rst_n(rst_n), .rx_en(rx_en), .rd_stb(rd_stb),
  .nine_bit(nine_bit), .addr_filt(addr_filt), .char_done(char_done),
  .char_bit9(char_word.bit9), .char_keep(char_keep), .fifo_full(fifo_full),
  .fifo_wr(fifo_wr), .fifo_level(fifo_level), .ovr_err(ovr_err), .rx_irq(rx_irq)
);

// File: tb/mdrop_rx_bench.sv
`timescale 1ns/1ps
module mdrop_rx_bench;
  localparam int TICK_DIV = 4;
  localparam int BIT_CLKS = 16 * TICK_DIV;
  localparam int NVEC     = 8;

  // {nine, filt, bit9, stop, keep, data[7:0]}
  localparam logic [12:0] VEC [NVEC] = '{
    {1'b0, 1'b0, 1'b0, 1'b1, 1'b1, 8'hA5},  // R2
    {1'b0, 1'b0, 1'b0, 1'b1, 1'b1, 8'h01},  // R2
    {1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 8'h80},  // R4
    {1'b1, 1'b0, 1'b1, 1'b1, 1'b1, 8'h3C},  // R3
    {1'b1, 1'b0, 1'b0, 1'b1, 1'b1, 8'hC3},  // R3
    {1'b1, 1'b1, 1'b0, 1'b1, 1'b0, 8'h55},  // R9 dropped
    {1'b1, 1'b1, 1'b1, 1'b1, 1'b1, 8'h7E},  // R9 kept
    {1'b0, 1'b1, 1'b0, 1'b1, 1'b1, 8'hF0}   // R9 inert in 8-bit
  };

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       rx_line = 1'b1;
  logic       os_tick = 1'b0;
  logic       rx_en = 1'b0;
  logic       nine_bit = 1'b0;
  logic       addr_filt = 1'b0;
  logic       rd_stb = 1'b0;
  logic [7:0] rd_data;
  logic       rd_bit9, rd_ferr, ovr_err, rx_irq;

  int n_chk = 0;
  int n_bad = 0;
  int div   = 0;

  always #2.5 clk = ~clk;

  always @(posedge clk) begin
    div     <= (div == TICK_DIV - 1) ? 0 : div + 1;
    os_tick <= (div == TICK_DIV - 1);
  end

  mdrop_rx u_mdrop_rx (
    .clk(clk), .rst_n(rst_n), .rx_line(rx_line), .os_tick(os_tick), .rx_en(rx_en),
    .nine_bit(nine_bit), .addr_filt(addr_filt), .rd_stb(rd_stb), .rd_data(rd_data),
    .rd_bit9(rd_bit9), .rd_ferr(rd_ferr), .ovr_err(ovr_err), .rx_irq(rx_irq)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic hold_line(input logic v, input int clks);
    rx_line = v;
    repeat (clks) @(negedge clk);
  endtask

  task automatic send(input logic [7:0] d, input logic nine, input logic b9, input logic stop);
    hold_line(1'b0, BIT_CLKS);
    for (int i = 0; i < 8; i++) hold_line(d[i], BIT_CLKS);
    if (nine) hold_line(b9, BIT_CLKS);
    hold_line(stop, BIT_CLKS);
    hold_line(1'b1, 2 * BIT_CLKS);
  endtask

  task automatic pop();
    rd_stb = 1'b1;
    @(negedge clk);
    rd_stb = 1'b0;
    @(negedge clk);
  endtask

  initial begin
    #(200000 * 5);
    n_bad++;
    $display("FAIL watchdog: actual hung expected done");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R1 irq", rx_irq, 0);
    check("R1 ovr", ovr_err, 0);
    rst_n = 1'b1;
    rx_en = 1'b1;
    repeat (3) @(negedge clk);

    for (int v = 0; v < NVEC; v++) begin
      nine_bit  = VEC[v][12];
      addr_filt = VEC[v][11];
      send(VEC[v][7:0], VEC[v][12], VEC[v][10], VEC[v][9]);
      if (VEC[v][8]) begin
        check("R6 irq", rx_irq, 1);
        check("R2 data", rd_data, VEC[v][7:0]);
        check("R3 bit9", rd_bit9, VEC[v][12] & VEC[v][10]);
        check("R4 ferr", rd_ferr, !VEC[v][9]);
        pop();
      end else begin
        check("R9 dropped", rx_irq, 0);
        check("R9 no ovr", ovr_err, 0);
      end
      check("R6 empty after", rx_irq, 0);
    end

    // R9: dropped chars with full queue do not raise overrun
    nine_bit = 1'b1; addr_filt = 1'b1;
    send(8'h11, 1'b1, 1'b1, 1'b1);
    send(8'h22, 1'b1, 1'b1, 1'b1);
    send(8'h33, 1'b1, 1'b0, 1'b1);
    check("R9 no ovr when full", ovr_err, 0);
    pop(); pop();
    nine_bit = 1'b0; addr_filt = 1'b0;

    // R5: short glitch
    hold_line(1'b0, 4 * TICK_DIV);
    hold_line(1'b1, 3 * BIT_CLKS);
    check("R5 glitch", rx_irq, 0);
    send(8'h5A, 1'b0, 1'b0, 1'b1);
    check("R5 after glitch", rd_data, 8'h5A);
    pop();

    // R6/R7: order and overrun
    send(8'h10, 1'b0, 1'b0, 1'b1);
    send(8'h20, 1'b0, 1'b0, 1'b1);
    check("R7 no ovr at two", ovr_err, 0);
    send(8'h30, 1'b0, 1'b0, 1'b1);
    check("R7 ovr", ovr_err, 1);
    check("R6 first", rd_data, 8'h10);
    pop();
    check("R6 second", rd_data, 8'h20);
    pop();
    check("R7 third dropped", rx_irq, 0);

    // R8: lockout and clear
    send(8'h40, 1'b0, 1'b0, 1'b1);
    check("R8 locked", rx_irq, 0);
    check("R8 still ovr", ovr_err, 1);
    rx_en = 1'b0; @(negedge clk); rx_en = 1'b1; @(negedge clk);
    check("R8 cleared", ovr_err, 0);
    send(8'h41, 1'b0, 1'b0, 1'b1);
    check("R8 resumes", rd_data, 8'h41);
    pop();

    // R10: read empty
    pop(); pop();
    check("R10 still empty", rx_irq, 0);
    send(8'h66, 1'b0, 1'b0, 1'b1);
    check("R10 data", rd_data, 8'h66);
    pop();
    check("R10 one entry", rx_irq, 0);

    // R11: disabled
    rx_en = 1'b0;
    send(8'h77, 1'b0, 1'b0, 1'b1);
    check("R11 disabled", rx_irq, 0);
    rx_en = 1'b1;

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule